// File: doc/BRIEF.md
# Floating-point operand unpack and classify

This block takes one raw register operand, up to 128 bits wide, together with a format code. It expands the operand into one internal form that every later arithmetic stage can consume unchanged. The internal form has a sign, a signed unbiased exponent, a 128-bit mantissa whose leading one always sits at bit 124, a sticky bit that is always clear, a class code and an invalid-operation flag.

Integers and subnormal floats are normalised inside the block by a leading-zero count and a left shift. Signalling NaNs are quieted on the way in. They stay distinguishable by their class code, and they raise the invalid flag. The operand is left-justified: its most significant 32-bit word is `opnd[127:96]`. Results are registered one clock after `in_valid`.

Top module: `fp_operand_unpack`

## Requirements
- R1: `out_sign` always equals `opnd[127]` of the accepted operand, for every format code. `out_sticky` is always 0.
- R2: Format codes are 0 int32 (`opnd[127:96]`), 1 int64 (`opnd[127:64]`), 2 single, 3 double and 4 quad. Codes 5 to 7 set `out_bad_fmt`, give class zero and a zero mantissa, and leave `out_invalid` clear.
- R3: Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN and 4 signalling NaN. A float with exponent field 0 and fraction 0, or an integer of value 0, gives class zero with mantissa 0 and exponent 0.
- R4: A normal float gives exponent = field − bias (bias 127, 1023 or 16383). The mantissa has bit 124 set and the fraction directly below it, with the fraction MSB at bit 123.
- R5: A subnormal float gives class number. Its mantissa is shifted left until bit 124 is set, and its exponent is 1 − bias minus that shift.
- R6: A nonzero integer gives class number and magnitude |value|, where the most negative value gives 2^31 or 2^63. The mantissa is normalised to bit 124, and the exponent is the bit index of the magnitude's leading one.
- R7: Exponent field all ones with fraction 0 gives class infinity, mantissa 0 and exponent 0.
- R8: Exponent field all ones with a nonzero fraction gives a NaN whose aligned fraction passes through, with exponent 0. If the top fraction bit is clear, bit 123 is set, the class is signalling NaN and `out_invalid` is 1. Otherwise the class is quiet NaN and `out_invalid` is 0.
- R9: `out_valid` rises exactly one clock after an accepted `in_valid`. Reset clears all outputs.
- R10: For class number, mantissa bits 127:125 are zero and bit 124 is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand accepted this cycle |
| fmt | input | 3 | Format code |
| opnd | input | 128 | Raw operand, left-justified |
| out_valid | output | 1 | Result valid |
| out_sign | output | 1 | Sign bit |
| out_exp | output | 18 | Unbiased exponent, two's complement |
| out_mant | output | 128 | Mantissa, leading one at bit 124 |
| out_sticky | output | 1 | Sticky bit, always 0 |
| out_cls | output | 3 | Class code |
| out_invalid | output | 1 | Invalid-operation flag |
| out_bad_fmt | output | 1 | Unsupported format code |

## Verification
The assertions assume that `fmt` and `opnd` are fully defined whenever `in_valid` is high. They also assume that `in_valid` is low while reset is applied, so that the one-cycle valid relation starts clean. The stimulus drives every input away from the active edge, holds `in_valid` low during reset, and uses only known values. It covers every class, all five formats, the extreme integers, the smallest subnormals, and the unsupported format codes.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;
  localparam int MANT_W   = 128;
  localparam int LEAD_POS = 124;
  localparam int EXP_W    = 18;

  typedef logic [MANT_W-1:0] mant_t;
  typedef logic signed [EXP_W-1:0] exp_t;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } cls_e;

  localparam logic [2:0] FMT_I32 = 3'd0;
  localparam logic [2:0] FMT_I64 = 3'd1;
  localparam logic [2:0] FMT_SGL = 3'd2;
  localparam logic [2:0] FMT_DBL = 3'd3;
  localparam logic [2:0] FMT_QUD = 3'd4;
endpackage

// File: rtl/fpu_lzc.sv
module fpu_lzc #(
  parameter int W  = 128,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] zeros
);
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpu_float_field.sv
module fpu_float_field
  import fpu_unpack_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW-1:0] ef,
  input  logic [FW-1:0] frac,
  output mant_t         pre,
  output exp_t          exp_base,
  output cls_e          cls,
  output logic          do_norm,
  output logic          inv
);
  localparam int   BIAS    = (1 << (EW - 1)) - 1;
  localparam exp_t SUB_EXP = EXP_W'(1 - BIAS);

  mant_t aligned;

  always_comb begin
    aligned = '0;
    aligned[LEAD_POS-1 -: FW] = frac;
  end

  always_comb begin
    pre      = '0;
    exp_base = '0;
    cls      = CLS_ZERO;
    do_norm  = 1'b0;
    inv      = 1'b0;
    if (ef == '0) begin
      if (frac != '0) begin
        pre      = aligned;
        exp_base = SUB_EXP;
        cls      = CLS_NUM;
        do_norm  = 1'b1;
      end
    end else if (ef == '1) begin
      if (frac != '0) begin
        pre = aligned;
        cls = CLS_QNAN;
        if (!aligned[LEAD_POS-1]) begin
          pre[LEAD_POS-1] = 1'b1;
          cls             = CLS_SNAN;
          inv             = 1'b1;
        end
      end else begin
        cls = CLS_INF;
      end
    end else begin
      pre           = aligned;
      pre[LEAD_POS] = 1'b1;
      exp_base      = $signed({{(EXP_W-EW){1'b0}}, ef}) - EXP_W'(BIAS);
      cls           = CLS_NUM;
    end
  end
endmodule

// File: rtl/fpu_normalizer.sv
module fpu_normalizer
  import fpu_unpack_pkg::*;
(
  input  mant_t pre,
  input  exp_t  exp_base,
  input  logic  enable,
  output mant_t mant,
  output exp_t  exp_out
);
  localparam int CW   = $clog2(MANT_W + 1);
  localparam int HEAD = MANT_W - 1 - LEAD_POS;

  logic [CW-1:0] zeros;
  logic [CW-1:0] shamt;

  fpu_lzc #(.W(MANT_W)) u_lzc (.din(pre), .zeros(zeros));

  always_comb begin
    shamt = '0;
    if (enable && pre != '0 && zeros >= CW'(HEAD)) shamt = zeros - CW'(HEAD);
    mant    = pre << shamt;
    exp_out = exp_base - $signed({{(EXP_W-CW){1'b0}}, shamt});
  end
endmodule

// File: rtl/fp_operand_unpack.sv
module fp_operand_unpack
  import fpu_unpack_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [2:0]   fmt,
  input  logic [127:0] opnd,
  output logic         out_valid,
  output logic         out_sign,
  output logic [17:0]  out_exp,
  output logic [127:0] out_mant,
  output logic         out_sticky,
  output logic [2:0]   out_cls,
  output logic         out_invalid,
  output logic         out_bad_fmt
);
  localparam int NFLT = 3;

  mant_t fl_pre  [NFLT];
  exp_t  fl_exp  [NFLT];
  cls_e  fl_cls  [NFLT];
  logic  fl_norm [NFLT];
  logic  fl_inv  [NFLT];

  for (genvar g = 0; g < NFLT; g++) begin : g_flt
    localparam int EW = (g == 0) ? 8  : (g == 1) ? 11 : 15;
    localparam int FW = (g == 0) ? 23 : (g == 1) ? 52 : 112;
    fpu_float_field #(.EW(EW), .FW(FW)) u_field (
      .ef      (opnd[126 -: EW]),
      .frac    (opnd[126-EW -: FW]),
      .pre     (fl_pre[g]),
      .exp_base(fl_exp[g]),
      .cls     (fl_cls[g]),
      .do_norm (fl_norm[g]),
      .inv     (fl_inv[g])
    );
  end

  logic [31:0] mag32;
  logic [63:0] mag64;
  mant_t pre_m;
  exp_t  pre_e;
  cls_e  pre_c;
  logic  pre_n, pre_i, pre_bad;
  mant_t nrm_m;
  exp_t  nrm_e;

  always_comb begin
    mag32 = opnd[127] ? (32'd0 - opnd[127:96]) : opnd[127:96];
    mag64 = opnd[127] ? (64'd0 - opnd[127:64]) : opnd[127:64];
  end

  always_comb begin
    pre_m   = '0;
    pre_e   = '0;
    pre_c   = CLS_ZERO;
    pre_n   = 1'b0;
    pre_i   = 1'b0;
    pre_bad = 1'b0;
    case (fmt)
      FMT_I32: if (mag32 != '0) begin
        pre_m = {96'd0, mag32};
        pre_e = EXP_W'(LEAD_POS);
        pre_c = CLS_NUM;
        pre_n = 1'b1;
      end
      FMT_I64: if (mag64 != '0) begin
        pre_m = {64'd0, mag64};
        pre_e = EXP_W'(LEAD_POS);
        pre_c = CLS_NUM;
        pre_n = 1'b1;
      end
      FMT_SGL, FMT_DBL, FMT_QUD: begin
        pre_m = fl_pre[fmt - FMT_SGL];
        pre_e = fl_exp[fmt - FMT_SGL];
        pre_c = fl_cls[fmt - FMT_SGL];
        pre_n = fl_norm[fmt - FMT_SGL];
        pre_i = fl_inv[fmt - FMT_SGL];
      end
      default: pre_bad = 1'b1;
    endcase
  end

  fpu_normalizer u_norm (
    .pre     (pre_m),
    .exp_base(pre_e),
    .enable  (pre_n),
    .mant    (nrm_m),
    .exp_out (nrm_e)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_sign    <= 1'b0;
      out_exp     <= '0;
      out_mant    <= '0;
      out_sticky  <= 1'b0;
      out_cls     <= CLS_ZERO;
      out_invalid <= 1'b0;
      out_bad_fmt <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign    <= opnd[127];
        out_exp     <= nrm_e;
        out_mant    <= nrm_m;
        out_sticky  <= 1'b0;
        out_cls     <= pre_c;
        out_invalid <= pre_i;
        out_bad_fmt <= pre_bad;
      end
    end
  end

  // R10
  num_lead_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cls == CLS_NUM) |-> (out_mant[127:125] == 3'b000 && out_mant[124]));
  // R8
  snan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> (out_cls == CLS_SNAN && out_mant[123]));
  // R1
  sticky_clear_chk: assert property (@(posedge clk) disable iff (rst) !out_sticky);
  // R2
  bad_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    out_bad_fmt |-> (out_cls == CLS_ZERO && !out_invalid && out_mant == '0));
  // R3
  zero_mant_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cls == CLS_ZERO) |-> out_mant == '0);
  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  sign_src_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_sign == $past(opnd[127]));
endmodule

// File: tb/tb_fp_operand_unpack.sv
module tb_fp_operand_unpack;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic [2:0] fmt;
  logic [127:0] opnd;
  logic out_valid, out_sign, out_sticky, out_invalid, out_bad_fmt;
  logic [17:0] out_exp;
  logic [127:0] out_mant;
  logic [2:0] out_cls;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic sign;
    logic [17:0] e;
    logic [127:0] m;
    logic [2:0] c;
    logic inv;
    logic bad;
    string tag;
  } item_t;

  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_operand_unpack dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fmt(fmt), .opnd(opnd),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_mant(out_mant), .out_sticky(out_sticky), .out_cls(out_cls),
    .out_invalid(out_invalid), .out_bad_fmt(out_bad_fmt)
  );

  function automatic int top_bit(logic [127:0] v);
    int p = -1;
    for (int i = 0; i < 128; i++) if (v[i]) p = i;
    return p;
  endfunction

  function automatic item_t model(logic [2:0] f, logic [127:0] x, string tag);
    item_t r;
    logic [63:0] mag;
    logic [127:0] fr;
    int ew, fw, bias, ef, p;
    r.sign = x[127]; r.e = '0; r.m = '0; r.c = 3'd0; r.inv = 1'b0; r.bad = 1'b0; r.tag = tag;
    if (f == 3'd0 || f == 3'd1) begin
      if (f == 3'd0) mag = {32'd0, x[127] ? (32'd0 - x[127:96]) : x[127:96]};
      else           mag = x[127] ? (64'd0 - x[127:64]) : x[127:64];
      if (mag != 0) begin
        p = top_bit({64'd0, mag});
        r.m = {64'd0, mag} << (124 - p);
        r.e = 18'(p);
        r.c = 3'd1;
      end
    end else if (f <= 3'd4) begin
      ew = (f == 3'd2) ? 8 : (f == 3'd3) ? 11 : 15;
      fw = (f == 3'd2) ? 23 : (f == 3'd3) ? 52 : 112;
      bias = (1 << (ew - 1)) - 1;
      ef = int'((x << 1) >> (128 - ew));
      fr = ((x << (1 + ew)) >> (128 - fw)) << (124 - fw);
      if (ef == 0) begin
        if (fr != 0) begin
          p = top_bit(fr);
          r.m = fr << (124 - p);
          r.e = 18'(1 - bias - (124 - p));
          r.c = 3'd1;
        end
      end else if (ef == (1 << ew) - 1) begin
        if (fr == 0) r.c = 3'd2;
        else begin
          r.m = fr;
          r.c = 3'd3;
          if (!fr[123]) begin r.m[123] = 1'b1; r.c = 3'd4; r.inv = 1'b1; end
        end
      end else begin
        r.m = fr | (128'd1 << 124);
        r.e = 18'(ef - bias);
        r.c = 3'd1;
      end
    end else begin
      r.bad = 1'b1;
    end
    return r;
  endfunction

  task automatic drive(logic [2:0] f, logic [127:0] x, string tag);
    @(negedge clk);
    in_valid = 1'b1; fmt = f; opnd = x;
    sb.push_back(model(f, x, tag));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      item_t ex;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R9: unexpected out_valid, actual 1 expected 0");
      end else begin
        ex = sb.pop_front();
        if (out_sign !== ex.sign || out_exp !== ex.e || out_mant !== ex.m ||
            out_cls !== ex.c || out_invalid !== ex.inv || out_bad_fmt !== ex.bad ||
            out_sticky !== 1'b0) begin
          errors++;
          $display("FAIL %s: actual s=%0b e=%0d m=%h c=%0d inv=%0b bad=%0b stk=%0b expected s=%0b e=%0d m=%h c=%0d inv=%0b bad=%0b stk=0",
                   ex.tag, out_sign, $signed(out_exp), out_mant, out_cls, out_invalid,
                   out_bad_fmt, out_sticky, ex.sign, $signed(ex.e), ex.m, ex.c, ex.inv, ex.bad);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; fmt = '0; opnd = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_cls !== 3'd0 || out_mant !== '0 || out_invalid !== 1'b0) begin
      errors++;
      $display("FAIL R9: reset state actual v=%0b c=%0d inv=%0b expected 0 0 0", out_valid, out_cls, out_invalid);
    end
    // R3 R6 integers
    drive(3'd0, 128'd0, "R3 int32 zero");
    drive(3'd0, {32'd1, 96'd0}, "R6 int32 one");
    drive(3'd0, {32'hFFFF_FFFF, 96'd0}, "R6 int32 minus one");
    drive(3'd0, {32'h8000_0000, 96'd0}, "R6 int32 most negative");
    drive(3'd0, {32'h7FFF_FFFF, 96'h5}, "R6 int32 max");
    drive(3'd1, {64'hFFFF_FFFF_FFFF_FFFB, 64'd0}, "R6 int64 minus five");
    drive(3'd1, {64'h8000_0000_0000_0000, 64'd0}, "R6 int64 most negative");
    drive(3'd1, 128'd0, "R3 int64 zero");
    // R4 normals
    drive(3'd2, {32'h3F80_0000, 96'd0}, "R4 single one");
    drive(3'd2, {32'hC0A0_0000, 96'd0}, "R4 single minus five");
    drive(3'd3, {64'h3FF8_0000_0000_0000, 64'd0}, "R4 double 1.5");
    drive(3'd4, {16'h3FFF, 112'd1}, "R4 quad near one");
    // R3 signed zero
    drive(3'd2, {32'h8000_0000, 96'd0}, "R3 single minus zero");
    // R5 subnormals
    drive(3'd2, {32'h0000_0001, 96'd0}, "R5 single min subnormal");
    drive(3'd2, {32'h0040_0000, 96'd0}, "R5 single top subnormal");
    drive(3'd3, {64'h0000_0000_0000_0001, 64'd0}, "R5 double min subnormal");
    drive(3'd4, 128'd1, "R5 quad min subnormal");
    // R7 R8 specials
    drive(3'd2, {32'hFF80_0000, 96'd0}, "R7 single minus inf");
    drive(3'd3, {64'h7FF0_0000_0000_0000, 64'd0}, "R7 double inf");
    drive(3'd2, {32'h7FC0_0001, 96'd0}, "R8 single quiet nan");
    drive(3'd2, {32'h7F80_0001, 96'd0}, "R8 single signalling nan");
    drive(3'd3, {64'h7FF0_0000_0000_0010, 64'd0}, "R8 double signalling nan");
    drive(3'd4, {16'hFFFF, 1'b0, 111'd3}, "R8 quad signalling nan");
    drive(3'd4, {16'h7FFF, 1'b1, 111'd0}, "R8 quad quiet nan");
    // R2 R1 bad formats
    drive(3'd5, {32'hBF80_0000, 96'd0}, "R2 R1 bad format 5");
    drive(3'd7, {32'h7F80_0001, 96'd0}, "R2 bad format 7");
    // R9 back to back
    @(negedge clk);
    in_valid = 1'b1; fmt = 3'd0; opnd = {32'd6, 96'd0};
    sb.push_back(model(3'd0, {32'd6, 96'd0}, "R9 back to back a"));
    @(negedge clk);
    fmt = 3'd2; opnd = {32'h4000_0000, 96'd0};
    sb.push_back(model(3'd2, {32'h4000_0000, 96'd0}, "R9 back to back b"));
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9: pending results actual %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule